// File: doc/BRIEF.md
# Scatter-Gather Stream-to-Memory Engine

This engine takes an incoming data stream and spreads each frame over memory buffers. A chain of descriptors in memory names those buffers. Each descriptor holds a link to the next descriptor, a buffer address, a byte capacity and a status word. The engine fetches the descriptor named by the current pointer and fills its buffer with stream beats. When the buffer is full or the frame ends, it writes a status word back and asks the owning register block to step the pointer on. When the descriptor it just finished is the tail, it raises an idle strobe.

A separate side-band stream carries per-frame application words. A message with the right word count is held until the frame's last beat and is then copied into the application area of the descriptor that closes the frame. Start-of-frame marking follows the frame across descriptors: only the first descriptor of a frame is flagged as a start.

The register block outside the engine owns the run, idle, current-pointer and tail-pointer state. It applies the engine's pointer-update and idle strobes on the next clock edge. Memory returns read data one cycle after a read request.

Top module: `s2m_sg_engine`

## Requirements
- R1: `s_ready_o` is high only while `run_i` is 1 and `idle_i` is 0. No descriptor is fetched while `run_i` is 0 or `idle_i` is 1.
- R2: After a synchronous reset, `s_ready_o` and every strobe and memory enable are low. The start-of-frame flag is 1.
- R3: A descriptor at address D is laid out as follows: the next pointer at D+0, the buffer address at D+4, the control word at D+8 (byte capacity in bits 22:0), the status word at D+12, and the application words at D+16 upward, one every 4 bytes.
- R4: A descriptor accepts at most floor(capacity / bytes-per-beat) beats. If the frame ends sooner, the buffer is only partly filled and the bytes after the last written beat are left untouched. Status bits 22:0 record the bytes actually written.
- R5: If a fetched descriptor already has status bit 31 set, the engine pulses `halt_o` and writes nothing. It then keeps `s_ready_o` low until `run_i` drops.
- R6: A side-band message is latched only if it has exactly APP_WORDS words, the last one marked with `c_last_i`. Any other length pulses `ctl_err_o` and leaves the latched words unchanged.
- R7: A descriptor that receives a frame's last beat gets status bit 26 set. It gets the latched application words at D+16 onward, and `cmpl_o` pulses together with its status write.
- R8: Status bit 27 is 1 on the first descriptor after reset and on any descriptor that follows one that closed a frame. Otherwise it is 0.
- R9: Every consumed descriptor has its status written with bit 31 set. The engine then pulses `ptr_upd_o` with the descriptor's next pointer. If the consumed descriptor equals `tail_ptr_i`, it also pulses `idle_set_o`.
- R10: Beat k of a descriptor is written to buffer address + k × bytes-per-beat, with the beat's data unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| run_i | input | 1 | Engine enabled |
| idle_i | input | 1 | Chain exhausted; no work |
| cur_ptr_i | input | AW | Address of the next descriptor to consume |
| tail_ptr_i | input | AW | Address of the last descriptor in the chain |
| s_data_i | input | DW | Stream beat data |
| s_valid_i | input | 1 | Stream beat valid |
| s_last_i | input | 1 | Beat ends the frame |
| s_ready_o | output | 1 | Engine accepts the beat |
| c_data_i | input | 32 | Side-band application word |
| c_valid_i | input | 1 | Side-band word valid |
| c_last_i | input | 1 | Side-band word ends the message |
| mem_rd_en_o | output | 1 | Descriptor read request |
| mem_rd_addr_o | output | AW | Descriptor read byte address |
| mem_rd_data_i | input | 32 | Read data, one cycle after the request |
| mem_wr_en_o | output | 1 | Memory write enable |
| mem_wr_addr_o | output | AW | Memory write byte address |
| mem_wr_data_o | output | DW | Memory write data |
| ptr_upd_o | output | 1 | Pulse: load `ptr_next_o` as the current pointer |
| ptr_next_o | output | AW | Next descriptor address |
| idle_set_o | output | 1 | Pulse: tail descriptor consumed |
| halt_o | output | 1 | Pulse: fetched descriptor was already complete |
| cmpl_o | output | 1 | Pulse: a frame finished in memory |
| ctl_err_o | output | 1 | Pulse: side-band message of the wrong length |

## Verification
The assertions take three things for granted:
- Memory answers a read exactly one cycle after the request.
- AW is at most 32 and DW at least 32.
- The register block applies `ptr_upd_o` and `idle_set_o` on the next edge, so the engine's one-cycle gap state sees fresh `cur_ptr_i` and `idle_i`.

The bench keeps within these limits with a memory model of fixed one-cycle latency and a register model that reacts on the following edge. It edits memory only while the engine is stopped or idle, and it holds `tail_ptr_i` steady while a chain is in flight. The sweep covers every frame length from 1 to 6 beats against capacities of 4, 8, 12 and 14 bytes, so buffers are filled exactly, partly, and with a capacity that is not a whole number of beats.

// File: rtl/s2m_pkg.sv
package s2m_pkg;
  localparam int LEN_W   = 23;
  localparam int WORD_W  = 32;
  // descriptor byte offsets (memory layout seen by software)
  localparam int OFF_NXT = 0;
  localparam int OFF_BUF = 4;
  localparam int OFF_CTL = 8;
  localparam int OFF_STS = 12;
  localparam int OFF_APP = 16;
  // status bit positions
  localparam int STS_CMPL = 31;
  localparam int STS_SOF  = 27;
  localparam int STS_EOF  = 26;

  typedef enum logic [2:0] {
    ST_WAIT, ST_FETCH, ST_XFER, ST_WB_APP, ST_WB_STS, ST_GAP, ST_HALT
  } state_t;

  function automatic logic [WORD_W-1:0] make_status(input logic sof, input logic eof,
                                                    input logic [LEN_W-1:0] nbytes);
    logic [WORD_W-1:0] w;
    w = '0;
    w[LEN_W-1:0] = nbytes;
    w[STS_EOF]   = eof;
    w[STS_SOF]   = sof;
    w[STS_CMPL]  = 1'b1;
    return w;
  endfunction
endpackage

// File: rtl/s2m_ctl_latch.sv
module s2m_ctl_latch
  import s2m_pkg::*;
#(
  parameter int APP_WORDS = 5
) (
  input  logic                                clk,
  input  logic                                rst,
  input  logic [WORD_W-1:0]                   c_data_i,
  input  logic                                c_valid_i,
  input  logic                                c_last_i,
  output logic [APP_WORDS-1:0][WORD_W-1:0]    app_o,
  output logic                                err_o
);
  localparam int CW = $clog2(APP_WORDS + 1);

  logic [CW-1:0]                     cnt_q;
  logic [APP_WORDS-2:0][WORD_W-1:0]  stage_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt_q   <= '0;
      stage_q <= '0;
      app_o   <= '0;
      err_o   <= 1'b0;
    end else begin
      err_o <= 1'b0;
      if (c_valid_i) begin
        if (c_last_i) begin
          cnt_q <= '0;
          if (cnt_q == CW'(APP_WORDS - 1)) app_o <= {c_data_i, stage_q};
          else                             err_o <= 1'b1;
        end else begin
          if (cnt_q < CW'(APP_WORDS - 1)) stage_q[cnt_q] <= c_data_i;
          if (cnt_q != CW'(APP_WORDS))    cnt_q <= cnt_q + CW'(1);
        end
      end
    end
  end

  // a rejected message must not disturb the words held for the frame
  p_err_keeps_app_r6: assert property (@(posedge clk) disable iff (rst)
    err_o |-> app_o == $past(app_o));
endmodule

// File: rtl/s2m_core.sv
module s2m_core
  import s2m_pkg::*;
#(
  parameter int AW        = 32,
  parameter int DW        = 32,
  parameter int APP_WORDS = 5
) (
  input  logic                              clk,
  input  logic                              rst,
  input  logic                              run_i,
  input  logic                              idle_i,
  input  logic [AW-1:0]                     cur_ptr_i,
  input  logic [AW-1:0]                     tail_ptr_i,
  input  logic [DW-1:0]                     s_data_i,
  input  logic                              s_valid_i,
  input  logic                              s_last_i,
  output logic                              s_ready_o,
  input  logic [APP_WORDS-1:0][WORD_W-1:0]  app_i,
  output logic                              mem_rd_en_o,
  output logic [AW-1:0]                     mem_rd_addr_o,
  input  logic [WORD_W-1:0]                 mem_rd_data_i,
  output logic                              mem_wr_en_o,
  output logic [AW-1:0]                     mem_wr_addr_o,
  output logic [DW-1:0]                     mem_wr_data_o,
  output logic                              ptr_upd_o,
  output logic [AW-1:0]                     ptr_next_o,
  output logic                              idle_set_o,
  output logic                              halt_o,
  output logic                              cmpl_o
);
  localparam int BPB  = DW / 8;
  localparam int BSH  = $clog2(BPB);
  localparam int WI_W = (APP_WORDS > 1) ? $clog2(APP_WORDS) : 1;

  state_t            st;
  logic [AW-1:0]     desc_q, nxt_q, buf_q;
  logic [LEN_W-1:0]  cap_q, cnt_q;
  logic [2:0]        fidx;
  logic [WI_W-1:0]   widx;
  logic              sof_q, eof_q;
  logic              accept;

  assign s_ready_o = (st == ST_XFER) && run_i && !idle_i;
  assign accept    = s_valid_i && s_ready_o;

  always_ff @(posedge clk) begin
    if (rst) begin
      st            <= ST_WAIT;
      desc_q        <= '0;
      nxt_q         <= '0;
      buf_q         <= '0;
      cap_q         <= '0;
      cnt_q         <= '0;
      fidx          <= '0;
      widx          <= '0;
      sof_q         <= 1'b1;
      eof_q         <= 1'b0;
      mem_rd_en_o   <= 1'b0;
      mem_rd_addr_o <= '0;
      mem_wr_en_o   <= 1'b0;
      mem_wr_addr_o <= '0;
      mem_wr_data_o <= '0;
      ptr_upd_o     <= 1'b0;
      ptr_next_o    <= '0;
      idle_set_o    <= 1'b0;
      halt_o        <= 1'b0;
      cmpl_o        <= 1'b0;
    end else begin
      mem_rd_en_o <= 1'b0;
      mem_wr_en_o <= 1'b0;
      ptr_upd_o   <= 1'b0;
      idle_set_o  <= 1'b0;
      halt_o      <= 1'b0;
      cmpl_o      <= 1'b0;
      unique case (st)
        ST_WAIT: begin
          if (run_i && !idle_i) begin
            desc_q        <= cur_ptr_i;
            mem_rd_en_o   <= 1'b1;
            mem_rd_addr_o <= cur_ptr_i + AW'(OFF_NXT);
            fidx          <= '0;
            st            <= ST_FETCH;
          end
        end
        ST_FETCH: begin
          // read words return one cycle after each request
          fidx <= fidx + 3'd1;
          case (fidx)
            3'd0: begin
              mem_rd_en_o   <= 1'b1;
              mem_rd_addr_o <= desc_q + AW'(OFF_BUF);
            end
            3'd1: begin
              nxt_q         <= mem_rd_data_i[AW-1:0];
              mem_rd_en_o   <= 1'b1;
              mem_rd_addr_o <= desc_q + AW'(OFF_CTL);
            end
            3'd2: begin
              buf_q         <= mem_rd_data_i[AW-1:0];
              mem_rd_en_o   <= 1'b1;
              mem_rd_addr_o <= desc_q + AW'(OFF_STS);
            end
            3'd3: cap_q <= mem_rd_data_i[LEN_W-1:0] >> BSH;
            default: begin
              if (mem_rd_data_i[STS_CMPL]) begin
                halt_o <= 1'b1;
                st     <= ST_HALT;
              end else begin
                cnt_q <= '0;
                eof_q <= 1'b0;
                st    <= (cap_q == '0) ? ST_WB_STS : ST_XFER;
              end
            end
          endcase
        end
        ST_XFER: begin
          if (accept) begin
            mem_wr_en_o   <= 1'b1;
            mem_wr_addr_o <= buf_q + (AW'(cnt_q) << BSH);
            mem_wr_data_o <= s_data_i;
            cnt_q         <= cnt_q + LEN_W'(1);
            if (s_last_i) begin
              eof_q <= 1'b1;
              widx  <= '0;
              st    <= ST_WB_APP;
            end else if (cnt_q + LEN_W'(1) == cap_q) begin
              st <= ST_WB_STS;
            end
          end
        end
        ST_WB_APP: begin
          mem_wr_en_o   <= 1'b1;
          mem_wr_addr_o <= desc_q + AW'(OFF_APP) + (AW'(widx) << 2);
          mem_wr_data_o <= DW'(app_i[widx]);
          widx          <= widx + WI_W'(1);
          if (widx == WI_W'(APP_WORDS - 1)) st <= ST_WB_STS;
        end
        ST_WB_STS: begin
          mem_wr_en_o   <= 1'b1;
          mem_wr_addr_o <= desc_q + AW'(OFF_STS);
          mem_wr_data_o <= DW'(make_status(sof_q, eof_q, cnt_q << BSH));
          cmpl_o        <= eof_q;
          ptr_upd_o     <= 1'b1;
          ptr_next_o    <= nxt_q;
          idle_set_o    <= (desc_q == tail_ptr_i);
          sof_q         <= eof_q;
          st            <= ST_GAP;
        end
        ST_GAP:  st <= ST_WAIT;   // lets the register block apply the strobes
        ST_HALT: if (!run_i) st <= ST_WAIT;
        default: st <= ST_WAIT;
      endcase
    end
  end

  p_cap_bound_r4: assert property (@(posedge clk) disable iff (rst)
    (st == ST_XFER) |-> cnt_q < cap_q);
  p_halt_quiet_r5: assert property (@(posedge clk) disable iff (rst)
    halt_o |-> !mem_wr_en_o && !ptr_upd_o);
  p_halt_no_write_r5: assert property (@(posedge clk) disable iff (rst)
    (st == ST_HALT) |=> !mem_wr_en_o);
  p_eof_status_r7: assert property (@(posedge clk) disable iff (rst)
    cmpl_o |-> mem_wr_en_o && mem_wr_data_o[STS_EOF]);
  p_wb_done_r9: assert property (@(posedge clk) disable iff (rst)
    ptr_upd_o |-> mem_wr_en_o && mem_wr_data_o[STS_CMPL]);
  p_beat_write_r10: assert property (@(posedge clk) disable iff (rst)
    accept |=> mem_wr_en_o && mem_wr_data_o == $past(s_data_i));
endmodule

// File: rtl/s2m_sg_engine.sv
module s2m_sg_engine
  import s2m_pkg::*;
#(
  parameter int AW        = 32,
  parameter int DW        = 32,
  parameter int APP_WORDS = 5
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              run_i,
  input  logic              idle_i,
  input  logic [AW-1:0]     cur_ptr_i,
  input  logic [AW-1:0]     tail_ptr_i,
  input  logic [DW-1:0]     s_data_i,
  input  logic              s_valid_i,
  input  logic              s_last_i,
  output logic              s_ready_o,
  input  logic [31:0]       c_data_i,
  input  logic              c_valid_i,
  input  logic              c_last_i,
  output logic              mem_rd_en_o,
  output logic [AW-1:0]     mem_rd_addr_o,
  input  logic [31:0]       mem_rd_data_i,
  output logic              mem_wr_en_o,
  output logic [AW-1:0]     mem_wr_addr_o,
  output logic [DW-1:0]     mem_wr_data_o,
  output logic              ptr_upd_o,
  output logic [AW-1:0]     ptr_next_o,
  output logic              idle_set_o,
  output logic              halt_o,
  output logic              cmpl_o,
  output logic              ctl_err_o
);
  logic [APP_WORDS-1:0][WORD_W-1:0] app_w;

  s2m_ctl_latch #(.APP_WORDS(APP_WORDS)) u_ctl (
    .clk(clk), .rst(rst),
    .c_data_i(c_data_i), .c_valid_i(c_valid_i), .c_last_i(c_last_i),
    .app_o(app_w), .err_o(ctl_err_o)
  );

  s2m_core #(.AW(AW), .DW(DW), .APP_WORDS(APP_WORDS)) u_core (
    .clk(clk), .rst(rst),
    .run_i(run_i), .idle_i(idle_i), .cur_ptr_i(cur_ptr_i), .tail_ptr_i(tail_ptr_i),
    .s_data_i(s_data_i), .s_valid_i(s_valid_i), .s_last_i(s_last_i), .s_ready_o(s_ready_o),
    .app_i(app_w),
    .mem_rd_en_o(mem_rd_en_o), .mem_rd_addr_o(mem_rd_addr_o), .mem_rd_data_i(mem_rd_data_i),
    .mem_wr_en_o(mem_wr_en_o), .mem_wr_addr_o(mem_wr_addr_o), .mem_wr_data_o(mem_wr_data_o),
    .ptr_upd_o(ptr_upd_o), .ptr_next_o(ptr_next_o), .idle_set_o(idle_set_o),
    .halt_o(halt_o), .cmpl_o(cmpl_o)
  );
endmodule

// File: tb/test_s2m_sg_engine.sv
module test_s2m_sg_engine;
  localparam int AW = 16;
  localparam int DW = 32;
  localparam int NAPP = 5;
  localparam int DB = 'h100;   // descriptor region, 0x40 apart
  localparam int BB = 'h800;   // buffer region, 0x40 apart

  logic clk = 1'b0, rst = 1'b1;
  always #10 clk = ~clk;

  logic run_r = 1'b0, ld = 1'b0, idle_r;
  logic [AW-1:0] ld_cur = '0, cur_r, tail_r = '0;
  logic [DW-1:0] s_data = '0;
  logic s_valid = 1'b0, s_last = 1'b0, s_ready;
  logic [31:0] c_data = '0;
  logic c_valid = 1'b0, c_last = 1'b0;
  logic rd_en, wr_en, ptr_upd, idle_set, halt, cmpl, ctl_err;
  logic [AW-1:0] rd_addr, wr_addr, ptr_next;
  logic [31:0] rd_data;
  logic [DW-1:0] wr_data;
  logic tb_we = 1'b0;
  logic [AW-1:0] tb_addr = '0;
  logic [31:0] tb_wdata = '0;
  logic [31:0] mem [0:4095];

  int total = 0, bad = 0;
  int n_cmpl = 0, n_idle = 0, n_upd = 0, n_halt = 0, n_err = 0;

  s2m_sg_engine #(.AW(AW), .DW(DW), .APP_WORDS(NAPP)) i_s2m_sg_engine (
    .clk(clk), .rst(rst), .run_i(run_r), .idle_i(idle_r), .cur_ptr_i(cur_r), .tail_ptr_i(tail_r),
    .s_data_i(s_data), .s_valid_i(s_valid), .s_last_i(s_last), .s_ready_o(s_ready),
    .c_data_i(c_data), .c_valid_i(c_valid), .c_last_i(c_last),
    .mem_rd_en_o(rd_en), .mem_rd_addr_o(rd_addr), .mem_rd_data_i(rd_data),
    .mem_wr_en_o(wr_en), .mem_wr_addr_o(wr_addr), .mem_wr_data_o(wr_data),
    .ptr_upd_o(ptr_upd), .ptr_next_o(ptr_next), .idle_set_o(idle_set),
    .halt_o(halt), .cmpl_o(cmpl), .ctl_err_o(ctl_err)
  );

  // register-block model: strobes take effect on the next edge
  always @(posedge clk) begin
    if (rst) begin
      idle_r <= 1'b1;
      cur_r  <= '0;
    end else if (ld) begin
      cur_r  <= ld_cur;
      idle_r <= 1'b0;
    end else begin
      if (ptr_upd)  cur_r  <= ptr_next;
      if (idle_set) idle_r <= 1'b1;
    end
  end

  // memory model with one-cycle read latency
  always @(posedge clk) begin
    if (rd_en) rd_data <= mem[rd_addr[13:2]];
    if (wr_en) mem[wr_addr[13:2]] <= wr_data;
    else if (tb_we) mem[tb_addr[13:2]] <= tb_wdata;
  end

  always @(posedge clk) if (!rst) begin
    n_cmpl <= n_cmpl + int'(cmpl);
    n_idle <= n_idle + int'(idle_set);
    n_upd  <= n_upd + int'(ptr_upd);
    n_halt <= n_halt + int'(halt);
    n_err  <= n_err + int'(ctl_err);
  end

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic finish_run();
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  endtask

  task automatic poke(input int a, input logic [31:0] d);
    tb_addr = AW'(a); tb_wdata = d; tb_we = 1'b1;
    @(negedge clk);
    tb_we = 1'b0;
  endtask

  task automatic clear_regions();
    for (int i = 0; i < 6 * 16; i++) begin
      poke(DB + 4 * i, 32'h0);
      poke(BB + 4 * i, 32'h0);
    end
  endtask

  task automatic put_desc(input int i, input int len, input logic [31:0] sts);
    poke(DB + i * 'h40 + 0,  32'(DB + (i + 1) * 'h40));
    poke(DB + i * 'h40 + 4,  32'(BB + i * 'h40));
    poke(DB + i * 'h40 + 8,  32'(len));
    poke(DB + i * 'h40 + 12, sts);
  endtask

  task automatic load_chain();
    ld_cur = AW'(DB); ld = 1'b1;
    @(negedge clk);
    ld = 1'b0;
  endtask

  task automatic send_ctl(input int n, input logic [31:0] base);
    for (int w = 0; w < n; w++) begin
      c_data = base + 32'(w); c_valid = 1'b1; c_last = (w == n - 1);
      @(negedge clk);
    end
    c_valid = 1'b0; c_last = 1'b0;
  endtask

  task automatic send_frame(input int n, input logic [31:0] base);
    for (int j = 0; j < n; j++) begin
      s_data = base + 32'(j); s_valid = 1'b1; s_last = (j == n - 1);
      while (!s_ready) @(negedge clk);
      @(negedge clk);
    end
    s_valid = 1'b0; s_last = 1'b0;
  endtask

  task automatic wait_idle();
    while (!idle_r) @(negedge clk);
    repeat (3) @(negedge clk);
  endtask

  function automatic logic [31:0] rdm(input int a);
    return mem[a[13:2]];
  endfunction

  initial begin
    repeat (400000) @(posedge clk);
    bad++; total++;
    $display("FAIL watchdog: run did not complete");
    finish_run();
  end

  initial begin
    int L, capb, k, b0, c0, i0, u0, e0, b, cnt;
    logic [31:0] exp_s, abase, dbase;
    repeat (3) @(negedge clk);
    // R2: reset state
    chk("R2 ready", 32'(s_ready), 0);
    chk("R2 wr_en", 32'(wr_en), 0);
    chk("R2 rd_en", 32'(rd_en), 0);
    chk("R2 strobes", {27'd0, ptr_upd, idle_set, halt, cmpl, ctl_err}, 0);
    rst = 1'b0;
    @(negedge clk);
    // R1: run set but idle -> refused
    run_r = 1'b1; s_valid = 1'b1;
    cnt = 0;
    repeat (4) begin @(negedge clk); cnt += int'(s_ready) + int'(rd_en); end
    chk("R1 idle blocks", 32'(cnt), 0);
    // R1: not running -> refused, no fetch
    run_r = 1'b0;
    load_chain();
    cnt = 0;
    repeat (6) begin @(negedge clk); cnt += int'(s_ready) + int'(rd_en); end
    chk("R1 stopped blocks", 32'(cnt), 0);
    s_valid = 1'b0;

    // sweep of capacities against frame lengths (R3 R4 R7 R8 R9 R10)
    for (int li = 0; li < 4; li++) begin
      for (int f = 1; f <= 6; f++) begin
        L = (li == 3) ? 14 : 4 * (li + 1);
        capb = L / 4;
        k = (f + capb - 1) / capb;
        abase = 32'hA000_0000 + 32'(li * 256 + f * 16);
        dbase = 32'hD000_0000 + 32'(li * 256 + f * 16);
        clear_regions();
        for (int i = 0; i < k; i++) put_desc(i, L, 32'h0);
        tail_r = AW'(DB + (k - 1) * 'h40);
        send_ctl(NAPP, abase);
        c0 = n_cmpl; i0 = n_idle; u0 = n_upd; e0 = n_err;
        load_chain();
        run_r = 1'b1;
        send_frame(f, dbase);
        wait_idle();
        run_r = 1'b0;
        chk("R7 one completion", 32'(n_cmpl - c0), 1);
        chk("R9 idle strobe", 32'(n_idle - i0), 1);
        chk("R9 advances", 32'(n_upd - u0), 32'(k));
        chk("R9 pointer", 32'(cur_r), 32'(DB + k * 'h40));
        chk("R6 good message", 32'(n_err - e0), 0);
        for (int i = 0; i < k; i++) begin
          b = ((f - i * capb) < capb ? (f - i * capb) : capb) * 4;
          exp_s = 32'h8000_0000 | 32'(b);
          if (i == 0)     exp_s[27] = 1'b1;
          if (i == k - 1) exp_s[26] = 1'b1;
          chk("R4 R7 R8 status", rdm(DB + i * 'h40 + 12), exp_s);
          chk("R4 untouched tail", rdm(BB + i * 'h40 + b), 32'h0);
        end
        for (int j = 0; j < f; j++)
          chk("R10 data", rdm(BB + (j / capb) * 'h40 + (j % capb) * 4), dbase + 32'(j));
        for (int w = 0; w < NAPP; w++)
          chk("R7 app words", rdm(DB + (k - 1) * 'h40 + 16 + 4 * w), abase + 32'(w));
        if (k > 1) chk("R7 no app mid-frame", rdm(DB + 16), 32'h0);
      end
    end

    // R5: pre-completed descriptor halts
    clear_regions();
    put_desc(0, 8, 32'h8000_0000);
    tail_r = AW'(DB);
    b0 = n_halt; u0 = n_upd;
    load_chain();
    run_r = 1'b1; s_valid = 1'b1; s_data = 32'h5555_AAAA;
    repeat (10) @(negedge clk);
    cnt = 0;
    repeat (6) begin @(negedge clk); cnt += int'(s_ready); end
    chk("R5 halt pulse", 32'(n_halt - b0), 1);
    chk("R5 ready held low", 32'(cnt), 0);
    chk("R5 no advance", 32'(n_upd - u0), 0);
    chk("R5 status kept", rdm(DB + 12), 32'h8000_0000);
    chk("R5 buffer kept", rdm(BB), 32'h0);
    s_valid = 1'b0; run_r = 1'b0;
    repeat (3) @(negedge clk);

    // R6 and R8 across frames
    clear_regions();
    for (int i = 0; i < 3; i++) put_desc(i, 8, 32'h0);
    tail_r = AW'(DB + 2 * 'h40);
    e0 = n_err; c0 = n_cmpl;
    send_ctl(NAPP, 32'hC0DE_0000);
    send_ctl(NAPP - 1, 32'hBAD0_0000);
    send_ctl(NAPP + 1, 32'hBAD1_0000);
    repeat (2) @(negedge clk);
    chk("R6 bad lengths flagged", 32'(n_err - e0), 2);
    load_chain();
    run_r = 1'b1;
    send_frame(2, 32'hF100_0000);
    send_frame(3, 32'hF200_0000);
    wait_idle();
    run_r = 1'b0;
    chk("R7 two completions", 32'(n_cmpl - c0), 2);
    chk("R8 d0 status", rdm(DB + 12), 32'h8C00_0008);
    chk("R8 d1 status", rdm(DB + 'h40 + 12), 32'h8800_0008);
    chk("R8 d2 status", rdm(DB + 'h80 + 12), 32'h8400_0004);
    for (int w = 0; w < NAPP; w++) begin
      chk("R6 app kept d0", rdm(DB + 16 + 4 * w), 32'hC0DE_0000 + 32'(w));
      chk("R6 app kept d2", rdm(DB + 'h80 + 16 + 4 * w), 32'hC0DE_0000 + 32'(w));
    end
    chk("R10 frame2 beat2", rdm(BB + 'h80), 32'hF200_0002);
    finish_run();
  end
endmodule